// File: doc/BRIEF.md
# DMA End-of-Transfer Terminator

This block decides when a DMA channel stops driving data on the local bus once an external end-of-transfer request arrives. A transfer begins with a programmed word count and a bus width of 8, 16 or 32 bits. Each 32-bit word takes four, two or one beats. A beat completes when the ready input is high or when the internal wait-state counter reports its terminal count. Without an end-of-transfer request the channel runs to the programmed count. It marks the final beat with the last-data strobe and then pulses done.

An end-of-transfer request ends the transfer early, and always at a word boundary. A mode input, captured at start, selects one of two ways to stop:

- **Mode 1:** the channel finishes the word in progress and stops there. It raises the last-data strobe only if that beat also closes a burst.
- **Mode 0:** the channel runs exactly one further word so that the last-data strobe falls on a true final word. That extra word is dropped when the FIFO reaches its limit at the end of the word in which the request was seen.

Address generation and FIFO storage live outside the block.

Top module: `eot_terminator`

## Requirements
- R1: A start pulse while idle with a nonzero count sets `active` on the next cycle, loads `words_left` with the count and loads `beats_left` with beats-per-word minus one. Beats per word are 4, 2 and 1 for `bus_width` codes 0 (8-bit), 1 (16-bit) and 2 (32-bit); code 3 behaves as 32-bit. A start with a zero count leaves the block idle.
- R2: A beat completes in a cycle where `active` is high and either `rdy` or `ws_zero` is high. After beats-per-word completed beats the word is done and `words_left` drops by one.
- R3: With no end-of-transfer request, the transfer ends after the programmed number of words. `last_strobe` is high only during the final beat of the final word.
- R4: In mode 1 (`mode_nolast`=1), a request ends the transfer when the word in which it was first seen completes. No further word follows.
- R5: In mode 1, `last_strobe` on that final beat equals `burst_last`. It is low whenever `burst_last` is low.
- R6: In mode 0, a request causes exactly one more word after the current one, with `last_strobe` high on the final beat of that extra word.
- R7: In mode 0, if `fifo_limit` is high on the beat that completes the word in which the request was seen, the extra word is skipped. That beat then ends the transfer with `last_strobe` low.
- R8: An early stop lands only on a word boundary. On an 8-bit bus all four byte beats of the word complete; on a 16-bit bus both halfword beats complete.
- R9: A one-cycle request that falls in a wait cycle, where neither `rdy` nor `ws_zero` is high, is latched and takes effect.
- R10: `done` is high for exactly one cycle, the cycle after the final beat completes. `active` is low in that cycle.
- R11: A request while idle has no effect: `active` stays low, and the next transfer runs to its full count.
- R12: A request seen during the last word by count ends the transfer at that count, with `last_strobe` on its final beat, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (honoured only while idle) |
| xfer_words | input | CNT_W | Number of 32-bit words to move |
| bus_width | input | 2 | 0: 8-bit, 1: 16-bit, 2 or 3: 32-bit |
| mode_nolast | input | 1 | 1: stop at current word; 0: run one extra word with strobe |
| eot_in | input | 1 | End-of-transfer request, active high |
| rdy | input | 1 | Ready: current beat completes |
| ws_zero | input | 1 | Wait-state counter terminal count: current beat completes |
| burst_last | input | 1 | Current beat is the last beat of a burst |
| fifo_limit | input | 1 | FIFO full (or empty) for the current direction |
| active | output | 1 | Transfer in progress |
| last_strobe | output | 1 | Last-data strobe for the current beat |
| done | output | 1 | One-cycle completion pulse |
| words_left | output | CNT_W | Words not yet completed |
| beats_left | output | 2 | Beats left in the current word after the current beat |

## Verification
The assertions assume that `bus_width` and `mode_nolast` are steady while a transfer starts. They also assume that `fifo_limit` and `burst_last` are only meaningful in the cycle of a completing beat. The bench changes inputs only a little after a rising edge and holds the width and mode for the whole transfer. It raises `fifo_limit` only on the beat that closes the word carrying the request, and pulses `eot_in` for a single cycle, sometimes inside a wait cycle. Programmed counts stay well below the counter range, and each end-of-transfer request falls inside the programmed word count.

// File: rtl/eot_term_pkg.sv
package eot_term_pkg;
   localparam int WORD_BYTES = 4;
   localparam int BEAT_W     = $clog2(WORD_BYTES);

   typedef enum logic [1:0] {
      BW_8   = 2'd0,
      BW_16  = 2'd1,
      BW_32  = 2'd2,
      BW_RSV = 2'd3
   } bus_w_e;

   // index of the final beat of a word for a given bus width
   function automatic logic [BEAT_W-1:0] final_beat(input bus_w_e w);
      logic [BEAT_W-1:0] r;
      case (w)
         BW_8:    r = BEAT_W'(WORD_BYTES - 1);
         BW_16:   r = BEAT_W'(WORD_BYTES / 2 - 1);
         default: r = '0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/eot_beat_ctr.sv
module eot_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BEAT_W-1:0] load_idx,
   input  logic              advance,
   output logic [BEAT_W-1:0] beat_idx,
   output logic              word_end
);
   if (BEAT_W < 1) begin : g_bad_w
      $error("eot_beat_ctr: BEAT_W must be at least 1");
   end

   logic [BEAT_W-1:0] top_q;
   logic [BEAT_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q <= '0;
         idx_q <= '0;
      end else if (load) begin
         top_q <= load_idx;
         idx_q <= load_idx;
      end else if (advance) begin
         idx_q <= (idx_q == '0) ? top_q : idx_q - BEAT_W'(1);
      end
   end

   assign beat_idx = idx_q;
   assign word_end = advance && (idx_q == '0);

   // R8
   beat_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= top_q);

   // R8
   beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load && idx_q == '0) |=> (idx_q == $past(top_q)));
endmodule

// File: rtl/eot_stop_ctl.sv
module eot_stop_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic start_load,
   input  logic mode_q,
   input  logic eot_s,
   input  logic word_end,
   input  logic final_cnt,
   input  logic fifo_limit,
   output logic stop_here_eff,
   output logic stop_next_eff,
   output logic finish
);
   logic eot_pend;
   logic stop_here;
   logic stop_next;
   logic eot_hit;

   assign eot_hit       = active && eot_s && !eot_pend;
   assign stop_here_eff = stop_here || (eot_hit && mode_q);
   assign stop_next_eff = stop_next || (eot_hit && !mode_q);
   assign finish        = word_end &&
                          (final_cnt || stop_here_eff || (stop_next_eff && fifo_limit));

   always_ff @(posedge clk) begin
      if (!rst_n || start_load || finish) begin
         eot_pend  <= 1'b0;
         stop_here <= 1'b0;
         stop_next <= 1'b0;
      end else begin
         if (eot_hit) begin
            eot_pend <= 1'b1;
         end
         if (word_end && stop_next_eff) begin
            stop_here <= 1'b1;
            stop_next <= 1'b0;
         end else begin
            stop_here <= stop_here_eff;
            stop_next <= stop_next_eff;
         end
      end
   end

   // R11
   idle_clears_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start_load) |=> !eot_pend);

   // R6
   extra_word_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && stop_next && !final_cnt && !fifo_limit && !start_load) |=> stop_here);

   // R4
   single_plan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_here && stop_next));
endmodule

// File: rtl/eot_terminator.sv
module eot_terminator #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [CNT_W-1:0]                  xfer_words,
   input  logic [1:0]                        bus_width,
   input  logic                              mode_nolast,
   input  logic                              eot_in,
   input  logic                              rdy,
   input  logic                              ws_zero,
   input  logic                              burst_last,
   input  logic                              fifo_limit,
   output logic                              active,
   output logic                              last_strobe,
   output logic                              done,
   output logic [CNT_W-1:0]                  words_left,
   output logic [eot_term_pkg::BEAT_W-1:0]   beats_left
);
   import eot_term_pkg::*;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("eot_terminator: CNT_W must be between 2 and 32");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("eot_terminator: SYNC_STAGES must be between 0 and 3");
   end

   logic              active_q;
   logic              mode_q;
   logic              done_q;
   logic [CNT_W-1:0]  words_q;
   logic              start_ok;
   logic              beat_done;
   logic              word_end;
   logic              final_cnt;
   logic              stop_here_eff;
   logic              stop_next_eff;
   logic              finish;
   logic              eot_s;
   logic [BEAT_W-1:0] beat_idx;

   // end-of-transfer sampling: direct, or through a flop chain
   if (SYNC_STAGES == 0) begin : g_eot_direct
      assign eot_s = eot_in;
   end else begin : g_eot_pipe
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            sh[0] <= eot_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               sh[i] <= sh[i-1];
            end
         end
      end
      assign eot_s = sh[SYNC_STAGES-1];
   end

   assign start_ok  = start && !active_q && (xfer_words != '0);
   assign beat_done = active_q && (rdy || ws_zero);
   assign final_cnt = (words_q == CNT_W'(1));

   eot_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_ok),
      .load_idx (final_beat(bus_w_e'(bus_width))),
      .advance  (beat_done),
      .beat_idx (beat_idx),
      .word_end (word_end)
   );

   eot_stop_ctl u_stop (
      .clk           (clk),
      .rst_n         (rst_n),
      .active        (active_q),
      .start_load    (start_ok),
      .mode_q        (mode_q),
      .eot_s         (eot_s),
      .word_end      (word_end),
      .final_cnt     (final_cnt),
      .fifo_limit    (fifo_limit),
      .stop_here_eff (stop_here_eff),
      .stop_next_eff (stop_next_eff),
      .finish        (finish)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         mode_q   <= 1'b0;
         done_q   <= 1'b0;
         words_q  <= '0;
      end else begin
         done_q <= finish;
         if (start_ok) begin
            active_q <= 1'b1;
            mode_q   <= mode_nolast;
            words_q  <= xfer_words;
         end else begin
            if (finish) begin
               active_q <= 1'b0;
            end
            if (word_end) begin
               words_q <= words_q - CNT_W'(1);
            end
         end
      end
   end

   assign active      = active_q;
   assign done        = done_q;
   assign words_left  = words_q;
   assign beats_left  = beat_idx;
   assign last_strobe = active_q && (beat_idx == '0) &&
                        (final_cnt || (stop_here_eff && (!mode_q || burst_last)));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !active);

   // R8
   stop_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(beat_idx) == '0 && $past(rdy || ws_zero)));

   // R5
   mode1_strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && mode_q && !final_cnt && !burst_last) |-> !last_strobe);

   // R2
   word_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_end && !start_ok) |=> (words_left == $past(words_left) - CNT_W'(1)));

   // R11
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start) |=> !active);

   // R3
   strobe_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_strobe |-> (active && beats_left == '0));
endmodule

// File: tb/sim_eot_terminator.sv
`timescale 1ns/1ps
module sim_eot_terminator;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] xfer_words = '0;
   logic [1:0]       bus_width = 2'd2;
   logic             mode_nolast = 1'b0;
   logic             eot_in = 1'b0;
   logic             rdy = 1'b0;
   logic             ws_zero = 1'b0;
   logic             burst_last = 1'b0;
   logic             fifo_limit = 1'b0;
   logic             active;
   logic             last_strobe;
   logic             done;
   logic [CNT_W-1:0] words_left;
   logic [1:0]       beats_left;

   always #2.5 clk = ~clk;

   eot_terminator #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer_words(xfer_words),
      .bus_width(bus_width), .mode_nolast(mode_nolast), .eot_in(eot_in),
      .rdy(rdy), .ws_zero(ws_zero), .burst_last(burst_last),
      .fifo_limit(fifo_limit), .active(active), .last_strobe(last_strobe),
      .done(done), .words_left(words_left), .beats_left(beats_left)
   );

   typedef struct {
      bit    last;
      bit    fin;
      string tag;
   } exp_t;

   exp_t  sb[$];
   int    n_checks = 0;
   int    n_fail = 0;
   bit    want_done = 0;
   string done_tag = "";
   bit    finished = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pop one expected item per completing beat
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (want_done) begin
            check(done && !active, {done_tag, " R10 done pulse"}, {done, active}, 2);
            want_done = 0;
         end else if (done) begin
            check(0, "R10 unexpected done", 1, 0);
         end
         if (active && (rdy || ws_zero)) begin
            if (sb.size() == 0) begin
               check(0, "R3 beat beyond expected end", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(last_strobe == e.last, {e.tag, " last strobe"}, last_strobe, e.last);
               if (e.fin) begin
                  want_done = 1;
                  done_tag  = e.tag;
               end
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // driver: predicts the beat sequence, pushes it, then drives the bus
   task automatic run(input int n, input int w, input bit md, input int e,
                      input bit cancel, input bit bl, input bit waits, input string tag);
      int bpw;
      int we;
      int fw;
      int total;
      bit lastv;
      bpw = (w == 0) ? 4 : (w == 1) ? 2 : 1;
      we  = (e >= 0) ? e / bpw : -1;
      if (e < 0 || we >= n - 1) begin
         fw = n - 1; lastv = 1;
      end else if (md) begin
         fw = we; lastv = bl;
      end else if (cancel) begin
         fw = we; lastv = 0;
      end else begin
         fw = we + 1; lastv = 1;
      end
      total = (fw + 1) * bpw;
      for (int b = 0; b < total; b++) begin
         exp_t it;
         it.last = (b == total - 1) ? lastv : 1'b0;
         it.fin  = (b == total - 1);
         it.tag  = tag;
         sb.push_back(it);
      end
      start = 1; xfer_words = CNT_W'(n); bus_width = 2'(w); mode_nolast = md;
      burst_last = bl;
      tick();
      start = 0;
      @(negedge clk);
      check(active && words_left == CNT_W'(n) && beats_left == 2'(bpw - 1),
            {tag, " R1 load"}, int'(words_left), n);
      tick();
      for (int b = 0; b < total; b++) begin
         int nw;
         nw = waits ? (b % 3) : 0;
         for (int k = 0; k <= nw; k++) begin
            eot_in = (b == e) && (k == 0);
            if (k < nw) begin
               rdy = 0; ws_zero = 0; fifo_limit = 0;
            end else begin
               rdy = (b % 2 == 1); ws_zero = (b % 2 == 0);
               fifo_limit = cancel && (b == (we + 1) * bpw - 1);
            end
            tick();
         end
         rdy = 0; ws_zero = 0; eot_in = 0; fifo_limit = 0;
      end
      tick();
      tick();
      check(!active, {tag, " R8 idle after stop"}, active, 0);
      check(sb.size() == 0, {tag, " R3 all beats consumed"}, sb.size(), 0);
      sb.delete();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      repeat (4) tick();
      @(negedge clk);
      check(!active && !done && !last_strobe && words_left == '0, "R1 reset state",
            active, 0);
      rst_n = 1;
      tick();

      // R1: zero count ignored
      start = 1; xfer_words = '0;
      tick();
      start = 0;
      @(negedge clk);
      check(!active, "R1 zero count ignored", active, 0);
      tick();

      run(3, 2, 0, -1, 0, 0, 1, "R2 R3 32-bit count end");
      run(2, 0, 1, -1, 0, 0, 1, "R8 8-bit count end");
      run(3, 3, 0, -1, 0, 0, 0, "R1 width code 3");
      run(5, 2, 1, 1, 0, 0, 0, "R4 mode1 stop");
      run(4, 0, 1, 5, 0, 1, 0, "R5 R8 mode1 strobe with burst end");
      run(3, 0, 1, 3, 0, 0, 0, "R4 R8 request on word's last byte");
      run(6, 1, 0, 2, 0, 0, 0, "R6 R8 mode0 extra word");
      run(6, 1, 0, 2, 1, 0, 0, "R7 mode0 fifo cancels extra");
      run(3, 0, 0, 1, 0, 0, 1, "R9 pulse in wait cycle");
      run(2, 2, 0, 1, 0, 0, 0, "R12 request in final word mode0");
      run(3, 1, 1, 4, 0, 1, 0, "R12 request in final word mode1");

      // R11: request while idle
      eot_in = 1;
      tick();
      eot_in = 0;
      @(negedge clk);
      check(!active && !done, "R11 idle request ignored", active, 0);
      tick();
      run(2, 2, 1, -1, 0, 0, 0, "R11 next transfer full count");

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule